// File: doc/BRIEF.md
# Multi-line receive FIFO with per-line resynchronisation purge

The block queues received characters from up to sixteen serial lines in one shared first-in first-out store. Each 16-bit entry carries a character, the number of the line it arrived on, two error flags and a marker flag. The consumer sees the oldest entry on `head_word` and takes it with a `pop` strobe. The entry stays at the output, unchanged, until it is taken, so error handling can copy it first.

When software asks for a line to be resynchronised, the block tags that line as purging and appends a marker word for it behind everything already queued. Entries for that line that reach the head while it is purging are dropped without being offered. When the line's own marker reaches the head, the marker is dropped as well and the purge ends. Other lines keep flowing. While a receive interrupt is outstanding, the output is frozen: nothing is offered and nothing is removed, but pushes still fill the store.

Top module: `rx_purge_fifo`

## Requirements
- R1: Entry layout is character in bits 7:0, line number in bits 11:8, parity error in bit 12, overrun in bit 13, bit 14 spare, marker flag in bit 15. A pushed data word is stored with bit 15 forced to 0, and all other bits are kept. A marker word has bit 15 set, the line number in bits 11:8 and all other bits 0.
- R2: Entries leave in arrival order. While `char_waiting` is high and `pop` is low, `head_word` does not change on the next cycle.
- R3: The store holds DEPTH (32) entries. A data push while full is dropped and sets `overflow`, which stays high until reset.
- R4: A `resync_req` pulse for line L, once accepted, sets `resync_expect[L]` on the next cycle and appends a marker for L behind everything queued. This includes a data word pushed in the same cycle. A request that finds no room stays pending until room appears.
- R5: While `resync_expect[L]` is set, a data entry for line L at the head is removed internally and `char_waiting` stays low for it.
- R6: A marker at the head is removed internally and clears `resync_expect` for its line. An expect bit falls only in this way.
- R7: While `irq_pending` is high, `char_waiting` is low, `pop` is ignored and no internal removal takes place. Pushes are still stored.
- R8: `pop` while `char_waiting` is low removes nothing.
- R9: `line_active[L]` is set when a data word for L is stored. It is cleared when a resync for L is accepted, and clearing wins over a same-cycle set.
- R10: At most one resync request is accepted per cycle, the lowest-numbered pending line first.
- R11: After reset the store is empty, `char_waiting` and `overflow` are 0, and all expect and active bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Store `push_word` this cycle |
| push_word | input | 16 | Received entry to store |
| resync_req | input | 16 | One pulse bit per line requesting resynchronisation |
| irq_pending | input | 1 | Receive interrupt outstanding; freezes the output |
| pop | input | 1 | Consume the offered head entry |
| head_word | output | 16 | Oldest stored entry |
| char_waiting | output | 1 | `head_word` is offered to the consumer |
| overflow | output | 1 | Sticky: a push was lost to a full store |
| resync_expect | output | 16 | Per-line purge in progress |
| line_active | output | 16 | Per-line receiver active |

## Verification
The assertions assume that `pop` is only meaningful while `char_waiting` is high. They also assume that `resync_req` bits are single-cycle pulses, and that the store depth is a power of two, so that pointer arithmetic stays in range. The random stimulus pulses request bits for one cycle only and issues pops freely, including against an empty or frozen output, so that the ignore rules are exercised. Line numbers are drawn from a small set, so that purges and markers for one line regularly meet traffic from other lines. Full-store overflow and marker back-pressure are reached by holding `irq_pending` high during long push bursts.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int LINE_W   = 4;
    localparam int WORD_W   = 16;
    localparam int NLINES   = 1 << LINE_W;
    localparam int LINE_LSB = 8;
    localparam int MARK_BIT = 15;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t make_marker(input line_t l);
        word_t w;
        w = '0;
        w[MARK_BIT] = 1'b1;
        w[LINE_LSB +: LINE_W] = l;
        return w;
    endfunction

    function automatic line_t line_of(input word_t w);
        return w[LINE_LSB +: LINE_W];
    endfunction
endpackage

// File: rtl/rxp_store.sv
module rxp_store
    import rxp_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic [$clog2(DEPTH)-1:0] wa_addr,
    input  word_t                    wa_data,
    input  logic                     wb_en,
    input  logic [$clog2(DEPTH)-1:0] wb_addr,
    input  word_t                    wb_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output word_t                    rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    word_t mem_view [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        word_t ent_d, ent_q;
        always_comb begin
            ent_d = ent_q;
            if (wa_en && wa_addr == PTR_W'(e)) ent_d = wa_data;
            if (wb_en && wb_addr == PTR_W'(e)) ent_d = wb_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end
        assign mem_view[e] = ent_q;
    end

    assign rd_data = mem_view[rd_addr];

    // R2: the two write ports never target the same slot
    assert_ports_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_addr != wb_addr));
endmodule

// File: rtl/rxp_lines.sv
module rxp_lines
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_i,
    input  logic              room_i,
    input  logic              data_set_i,
    input  line_t             data_line_i,
    input  logic              mark_clr_i,
    input  line_t             mark_line_i,
    output logic              accept_o,
    output line_t             accept_line_o,
    output logic [NLINES-1:0] expect_o,
    output logic [NLINES-1:0] active_o
);
    typedef struct packed {
        logic [NLINES-1:0] pend;
        logic [NLINES-1:0] expct;
        logic [NLINES-1:0] active;
    } lines_st_t;

    localparam logic [NLINES-1:0] ONE = {{(NLINES-1){1'b0}}, 1'b1};

    lines_st_t st_d, st_q;
    logic [NLINES-1:0] pending_w, acc_mask_w, set_mask_w, clr_mask_w;
    logic              found_w;
    line_t             low_w;

    always_comb begin
        pending_w = st_q.pend | req_i;
        found_w   = 1'b0;
        low_w     = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (pending_w[i]) begin
                found_w = 1'b1;
                low_w   = line_t'(i);
            end
        end
        accept_o      = found_w && room_i;
        accept_line_o = low_w;
        acc_mask_w    = accept_o   ? (ONE << low_w)       : '0;
        set_mask_w    = data_set_i ? (ONE << data_line_i) : '0;
        clr_mask_w    = mark_clr_i ? (ONE << mark_line_i) : '0;

        st_d        = st_q;
        st_d.pend   = pending_w & ~acc_mask_w;
        st_d.expct  = (st_q.expct & ~clr_mask_w) | acc_mask_w;
        st_d.active = (st_q.active | set_mask_w) & ~acc_mask_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expect_o = st_q.expct;
    assign active_o = st_q.active;

    // R10: one acceptance per cycle
    assert_single_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_mask_w));
    // R4: accepted line shows its expect bit next cycle
    assert_expect_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> expect_o[$past(accept_line_o)]);
    // R6: expect bits only fall when a marker leaves
    assert_expect_falls_on_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mark_clr_i |=> ((expect_o & $past(expect_o)) == $past(expect_o)));
    // R9: an accepted line is inactive afterwards
    assert_active_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !active_o[$past(accept_line_o)]);
endmodule

// File: rtl/rx_purge_fifo.sv
module rx_purge_fifo
    import rxp_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [15:0]       push_word,
    input  logic [NLINES-1:0] resync_req,
    input  logic              irq_pending,
    input  logic              pop,
    output logic [15:0]       head_word,
    output logic              char_waiting,
    output logic              overflow,
    output logic [NLINES-1:0] resync_expect,
    output logic [NLINES-1:0] line_active
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    word_t            head_w, data_w;
    line_t            head_line_w;
    logic             head_valid_w, purge_w, deq_w, data_acc_w, room_w, accept_w;
    line_t            accept_line_w;
    logic [CNT_W:0]   occ_w;
    logic             wa_en_w, wb_en_w;
    logic [PTR_W-1:0] wb_addr_w;
    word_t            wa_data_w, marker_w;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input logic [1:0] n);
        logic [PTR_W+1:0] t;
        t = (PTR_W+2)'(p) + (PTR_W+2)'(n);
        if (t >= (PTR_W+2)'(DEPTH)) t = t - (PTR_W+2)'(DEPTH);
        return t[PTR_W-1:0];
    endfunction

    rxp_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en_w),
        .wa_addr (st_q.wr_ptr),
        .wa_data (wa_data_w),
        .wb_en   (wb_en_w),
        .wb_addr (wb_addr_w),
        .wb_data (marker_w),
        .rd_addr (st_q.rd_ptr),
        .rd_data (head_w)
    );

    rxp_lines u_lines (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (resync_req),
        .room_i        (room_w),
        .data_set_i    (data_acc_w),
        .data_line_i   (line_of(push_word)),
        .mark_clr_i    (deq_w && head_w[MARK_BIT]),
        .mark_line_i   (head_line_w),
        .accept_o      (accept_w),
        .accept_line_o (accept_line_w),
        .expect_o      (resync_expect),
        .active_o      (line_active)
    );

    always_comb begin
        head_valid_w = (st_q.count != '0);
        head_line_w  = line_of(head_w);
        purge_w      = head_valid_w && !irq_pending
                       && (head_w[MARK_BIT] || resync_expect[head_line_w]);
        char_waiting = head_valid_w && !irq_pending && !purge_w;
        deq_w        = purge_w || (char_waiting && pop);

        data_acc_w   = push_valid && (st_q.count < CNT_W'(DEPTH));
        occ_w        = (CNT_W+1)'(st_q.count) + (CNT_W+1)'(data_acc_w);
        room_w       = occ_w < (CNT_W+1)'(DEPTH);

        data_w           = push_word;
        data_w[MARK_BIT] = 1'b0;
        marker_w         = make_marker(accept_line_w);
        wa_en_w          = data_acc_w || accept_w;
        wa_data_w        = data_acc_w ? data_w : marker_w;
        wb_en_w          = data_acc_w && accept_w;
        wb_addr_w        = adv(st_q.wr_ptr, 2'd1);

        st_d        = st_q;
        st_d.wr_ptr = adv(st_q.wr_ptr, {1'b0, data_acc_w} + {1'b0, accept_w});
        st_d.rd_ptr = adv(st_q.rd_ptr, {1'b0, deq_w});
        st_d.count  = st_q.count + CNT_W'(data_acc_w) + CNT_W'(accept_w) - CNT_W'(deq_w);
        st_d.ovf    = st_q.ovf || (push_valid && !data_acc_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_word = head_w;
    assign overflow  = st_q.ovf;

    // R3: occupancy never exceeds the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
    // R3: overflow is sticky
    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R2: an offered entry is held until popped
    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_waiting && !pop) |=> $stable(head_word));
    // R7: nothing leaves while an interrupt is outstanding
    assert_irq_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |=> st_q.count >= $past(st_q.count));
    // R8: a pop with nothing offered removes nothing unless a purge ran
    assert_idle_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !char_waiting && !purge_w) |=> st_q.count >= $past(st_q.count));
endmodule

// File: tb/rx_purge_fifo_bench.sv
module rx_purge_fifo_bench;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_word = '0;
    logic [15:0] resync_req = '0;
    logic        irq_pending = 1'b0;
    logic        pop = 1'b0;
    logic [15:0] head_word;
    logic        char_waiting, overflow;
    logic [15:0] resync_expect, line_active;

    int errors = 0;
    int checks = 0;

    logic [15:0] mq[$];
    logic [15:0] m_exp = '0, m_act = '0, m_pend = '0;
    bit          m_ovf = 1'b0;

    always #5 clk = ~clk;

    rx_purge_fifo #(.DEPTH(DEPTH)) u_rx_purge_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .resync_req(resync_req), .irq_pending(irq_pending), .pop(pop),
        .head_word(head_word), .char_waiting(char_waiting), .overflow(overflow),
        .resync_expect(resync_expect), .line_active(line_active)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_purge(input bit irq);
        if (mq.size() == 0 || irq) return 1'b0;
        return mq[0][15] || m_exp[mq[0][11:8]];
    endfunction

    function automatic bit m_wait(input bit irq);
        return mq.size() != 0 && !irq && !m_purge(irq);
    endfunction

    // compare outputs against the model, then advance the model by one cycle
    task automatic step(input bit pv, input logic [15:0] w, input logic [15:0] rq,
                        input bit irq, input bit pp);
        bit cw, dq, dacc, found, room;
        int cnt, low;
        logic [15:0] pendv;
        @(negedge clk);
        push_valid = pv; push_word = w; resync_req = rq; irq_pending = irq; pop = pp;
        #1;
        cw = m_wait(irq);
        chk(char_waiting == cw, "R5 R6 R7 waiting", 32'(char_waiting), 32'(cw));
        if (cw) chk(head_word == mq[0], "R2 head order", 32'(head_word), 32'(mq[0]));
        chk(overflow == m_ovf, "R3 overflow", 32'(overflow), 32'(m_ovf));
        chk(resync_expect == m_exp, "R4 R6 expect", 32'(resync_expect), 32'(m_exp));
        chk(line_active == m_act, "R9 active", 32'(line_active), 32'(m_act));
        dq   = m_purge(irq) || (cw && pp);
        cnt  = mq.size();
        dacc = pv && cnt < DEPTH;
        if (pv && !dacc) m_ovf = 1'b1;
        pendv = m_pend | rq;
        found = 1'b0; low = 0;
        for (int i = 15; i >= 0; i--) if (pendv[i]) begin found = 1'b1; low = i; end
        room = (cnt + int'(dacc)) < DEPTH;
        if (dq) begin
            if (mq[0][15]) m_exp[mq[0][11:8]] = 1'b0;
            void'(mq.pop_front());
        end
        if (dacc) begin
            mq.push_back(w & 16'h7fff);
            m_act[w[11:8]] = 1'b1;
        end
        if (found && room) begin
            mq.push_back({1'b1, 3'b000, 4'(low), 8'h00});
            pendv[low] = 1'b0;
            m_exp[low] = 1'b1;
            m_act[low] = 1'b0;
        end
        m_pend = pendv;
    endtask

    function automatic logic [15:0] rnd_word();
        logic [15:0] v;
        v = 16'($urandom);
        v[11:8] = 4'($urandom_range(0, 3));
        return v;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(char_waiting == 1'b0, "R11 waiting", 32'(char_waiting), 0);
        chk(overflow == 1'b0, "R11 overflow", 32'(overflow), 0);
        chk(resync_expect == '0 && line_active == '0, "R11 line bits",
            {resync_expect, line_active}, 0);
        rst_n = 1'b1;

        // R1: marker bit of pushed data is forced low, other bits kept
        step(1, 16'hF3A5, '0, 0, 0);
        step(0, '0, '0, 0, 0);
        chk(head_word == 16'h73A5, "R1 data bit15", 32'(head_word), 32'h73A5);
        chk(line_active[3] == 1'b1, "R9 set on store", 32'(line_active), 32'h8);
        step(0, '0, '0, 0, 1);
        // R8: pops against an empty store
        step(0, '0, '0, 0, 1);
        step(0, '0, '0, 0, 1);
        chk(char_waiting == 1'b0, "R8 empty pop", 32'(char_waiting), 0);

        // R3 R7: fill while frozen, then overflow
        for (int i = 0; i < DEPTH + 3; i++) step(1, rnd_word(), '0, 1, 1);
        step(0, '0, '0, 1, 0);
        chk(overflow == 1'b1, "R3 sticky overflow", 32'(overflow), 1);
        // R4: request with no room stays pending
        step(0, '0, 16'h0004, 1, 0);
        step(0, '0, '0, 1, 0);
        chk(resync_expect[2] == 1'b0, "R4 wait for room", 32'(resync_expect), 0);
        for (int i = 0; i < DEPTH + 8; i++) step(0, '0, '0, 0, 1);

        // R10: two requests at once, lowest line first
        step(1, 16'h0511, 16'h0022, 0, 0);
        step(0, '0, '0, 0, 0);
        chk(resync_expect[1] == 1'b1 && resync_expect[5] == 1'b0, "R10 lowest first",
            32'(resync_expect), 32'h2);
        chk(line_active[5] == 1'b1, "R9 active before accept", 32'(line_active), 32'h20);
        step(0, '0, '0, 0, 0);
        chk(resync_expect[5] == 1'b1 && line_active[5] == 1'b0, "R9 R4 second accept",
            32'(resync_expect), 32'h22);
        for (int i = 0; i < 12; i++) step(0, '0, '0, 0, 1);

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 3000; c++) begin
                bit pv, irq, pp;
                logic [15:0] rq;
                pv  = ($urandom_range(0, 99) < (ph == 2 ? 85 : 50));
                irq = ($urandom_range(0, 99) < (ph == 1 ? 40 : 8));
                pp  = ($urandom_range(0, 99) < (ph == 2 ? 30 : 60));
                rq  = '0;
                if ($urandom_range(0, 99) < (ph == 3 ? 12 : 3))
                    rq[$urandom_range(0, 3)] = 1'b1;
                step(pv, rnd_word(), rq, irq, pp);
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule